// File: doc/BRIEF.md
# Ordering-Table Clear DMA Engine

This engine fills a region of memory with an empty, backward-linked list of pointer words. Software loads a start address and an entry count, then writes a run code into the channel-control register. The engine walks downward from the word-aligned start address. It issues one word write per accepted cycle on a write-only memory port. Each entry holds the address of the entry just below it, except the lowest entry written, which holds the end-of-list marker 0x00FFFFFF.

When the final entry has been accepted, the engine clears the busy and trigger bits of the control register and pulses its interrupt. A control write that sets the busy bit with any value other than the run code is rejected: nothing is written to memory, the stored value has both bits cleared, and the interrupt is still pulsed. The walk never goes below a parameterised memory floor. It ends early at the floor and places the marker there.

Top module: `otc_clear_dma`

## Requirements
- R1: After reset, `ctrl_out` is 0, `irq` is low and `mem_wr_valid` is low.
- R2: A write with `cfg_sel` = 0 loads the start address, 1 loads the entry count and 2 loads the control register (3 is ignored). A control write of exactly 0x11000002 starts a walk, and bit 24 of `ctrl_out` reads 1 while the walk runs.
- R3: The two low bits of the start address are ignored, and the first entry goes to the start address rounded down to a multiple of 4.
- R4: Each non-final entry written at address A carries (A − 4) in bits 23:0 and zero in bits 31:24. The next entry goes to A − 4.
- R5: For a count N ≥ 1 with room above the floor, exactly N entries are written, and the N-th holds 0x00FFFFFF.
- R6: A count of zero writes a single 0x00FFFFFF entry at the aligned start address.
- R7: No entry is written below `MEM_FLOOR`. An entry at an address below `MEM_FLOOR`+4 is the last one and holds 0x00FFFFFF.
- R8: In the cycle after the final entry is accepted, bits 28 and 24 of `ctrl_out` are 0 and the other bits are kept. `irq` is high for exactly that one cycle.
- R9: A control write with bit 24 set and a value other than 0x11000002 writes no memory. It stores the value with bits 28 and 24 cleared and pulses `irq` once in the next cycle.
- R10: While `mem_wr_ready` is low, `mem_wr_valid` stays high and address and data stay unchanged. At most one entry is consumed per cycle.
- R11: While bit 24 of `ctrl_out` is set, every register write is ignored, including one that arrives in the cycle the final entry is accepted.
- R12: A control write with bit 24 clear is stored as written and starts nothing. It raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start address, 1 count, 2 control |
| cfg_wdata | input | 32 | Register write data |
| ctrl_out | output | 32 | Current control register value (bit 24 busy, bit 28 trigger) |
| irq | output | 1 | One-cycle completion interrupt |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the presented write |
| mem_wr_addr | output | PTR_W | Byte address of the entry |
| mem_wr_data | output | 32 | Entry value |

## Verification
Two functions can meet in a single cycle: completion of the walk, and a control-register write that would start a fresh walk. The bench keeps the memory ready at all times and counts cycles from the run command. It places a second run command exactly on the edge that accepts the last entry. The expected result is that completion takes effect and the command is dropped. After the collision `ctrl_out` must read 0x00000002, and no further memory writes may appear. A separate case stalls the port for several cycles while writes to the start address and count are attempted. A later run with no new configuration must then reuse the original address and count.

// File: rtl/otc_pkg.sv
package otc_pkg;

   typedef enum logic [1:0] {
      OTC_SEL_BASE  = 2'd0,
      OTC_SEL_COUNT = 2'd1,
      OTC_SEL_CTRL  = 2'd2,
      OTC_SEL_SPARE = 2'd3
   } otc_sel_e;

   typedef enum logic [1:0] {
      OTC_CMD_NONE,
      OTC_CMD_STORE,
      OTC_CMD_RUN,
      OTC_CMD_REJECT
   } otc_cmd_e;

   localparam int          OTC_BUSY_BIT  = 24;
   localparam int          OTC_TRIG_BIT  = 28;
   localparam logic [31:0] OTC_RUN_CODE  = 32'h1100_0002;
   localparam logic [31:0] OTC_TERM_WORD = 32'h00FF_FFFF;
   localparam logic [31:0] OTC_CLR_MASK  = (32'd1 << OTC_BUSY_BIT) | (32'd1 << OTC_TRIG_BIT);

endpackage

// File: rtl/otc_cmd_decode.sv
module otc_cmd_decode
   import otc_pkg::*;
(
   input  logic             cfg_we,
   input  otc_sel_e         cfg_sel,
   input  logic [31:0]      cfg_wdata,
   input  logic             busy,
   output logic             base_we,
   output logic             count_we,
   output otc_cmd_e         cmd
);

   always_comb begin
      base_we  = 1'b0;
      count_we = 1'b0;
      cmd      = OTC_CMD_NONE;
      if (cfg_we && !busy) begin
         case (cfg_sel)
            OTC_SEL_BASE:  base_we  = 1'b1;
            OTC_SEL_COUNT: count_we = 1'b1;
            OTC_SEL_CTRL: begin
               if (!cfg_wdata[OTC_BUSY_BIT])
                  cmd = OTC_CMD_STORE;
               else if (cfg_wdata == OTC_RUN_CODE)
                  cmd = OTC_CMD_RUN;
               else
                  cmd = OTC_CMD_REJECT;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/otc_ctrl_regs.sv
module otc_ctrl_regs
   import otc_pkg::*;
#(
   parameter int PTR_W = 24,
   parameter int CNT_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic              count_we,
   input  otc_cmd_e          cmd,
   input  logic [31:0]       wdata,
   input  logic              walk_done,
   output logic [PTR_W-1:0]  base_q,
   output logic [CNT_W-1:0]  count_q,
   output logic [31:0]       ctrl_q,
   output logic              busy,
   output logic              irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         count_q <= '0;
      end else begin
         if (base_we)  base_q  <= wdata[PTR_W-1:0];
         if (count_we) count_q <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         irq    <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (walk_done) begin
            ctrl_q <= ctrl_q & ~OTC_CLR_MASK;
            irq    <= 1'b1;
         end else begin
            case (cmd)
               OTC_CMD_STORE,
               OTC_CMD_RUN:    ctrl_q <= wdata;
               OTC_CMD_REJECT: begin
                  ctrl_q <= wdata & ~OTC_CLR_MASK;
                  irq    <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign busy = ctrl_q[OTC_BUSY_BIT];

   assert_done_only_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |-> busy);

   assert_irq_leaves_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!ctrl_q[OTC_BUSY_BIT] && !ctrl_q[OTC_TRIG_BIT]));

endmodule

// File: rtl/otc_walker.sv
module otc_walker
   import otc_pkg::*;
#(
   parameter int PTR_W     = 24,
   parameter int CNT_W     = 24,
   parameter int MEM_FLOOR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PTR_W-1:0]  base,
   input  logic [CNT_W-1:0]  count,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [PTR_W-1:0]  mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   output logic              done
);

   localparam logic [PTR_W-1:0] ALIGN_MASK = ~PTR_W'(3);
   localparam logic [PTR_W-1:0] STEP       = PTR_W'(4);
   localparam logic [PTR_W-1:0] FLOOR_STOP = PTR_W'(MEM_FLOOR + 4);
   localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

   if (PTR_W < 8 || PTR_W > 32) begin : g_bad_ptr
      $error("otc_walker: PTR_W must lie in 8..32");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("otc_walker: CNT_W must lie in 1..32");
   end
   if ((MEM_FLOOR % 4) != 0) begin : g_bad_floor
      $error("otc_walker: MEM_FLOOR must be word aligned");
   end

   logic              active;
   logic [PTR_W-1:0]  cur_addr;
   logic [CNT_W-1:0]  remain;
   logic              is_last;
   logic [PTR_W-1:0]  link;
   logic [31:0]       link_word;

   assign is_last = (remain <= ONE) || (cur_addr < FLOOR_STOP);
   assign link    = cur_addr - STEP;

   if (PTR_W >= 24) begin : g_link_wide
      assign link_word = {8'h00, link[23:0]};
   end else begin : g_link_narrow
      assign link_word = 32'(link);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
      end else if (start) begin
         active   <= 1'b1;
         cur_addr <= base & ALIGN_MASK;
         remain   <= count;
      end else if (active && mem_wr_ready) begin
         if (is_last) begin
            active <= 1'b0;
         end else begin
            cur_addr <= link;
            remain   <= remain - ONE;
         end
      end
   end

   assign mem_wr_valid = active;
   assign mem_wr_addr  = cur_addr;
   assign mem_wr_data  = is_last ? OTC_TERM_WORD : link_word;
   assign done         = active && mem_wr_ready && is_last;

   assert_descend_by_four_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && mem_wr_ready && !done) |=>
         (mem_wr_valid && mem_wr_addr == $past(mem_wr_addr) - STEP));

   assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

   assert_no_restart_while_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !active);

endmodule

// File: rtl/otc_clear_dma.sv
module otc_clear_dma
   import otc_pkg::*;
#(
   parameter int PTR_W     = 24,
   parameter int CNT_W     = 24,
   parameter int MEM_FLOOR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       ctrl_out,
   output logic              irq,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [PTR_W-1:0]  mem_wr_addr,
   output logic [31:0]       mem_wr_data
);

   logic              base_we;
   logic              count_we;
   otc_cmd_e          cmd;
   logic              busy;
   logic              walk_done;
   logic [PTR_W-1:0]  base_q;
   logic [CNT_W-1:0]  count_q;

   otc_cmd_decode i_decode (
      .cfg_we    (cfg_we),
      .cfg_sel   (otc_sel_e'(cfg_sel)),
      .cfg_wdata (cfg_wdata),
      .busy      (busy),
      .base_we   (base_we),
      .count_we  (count_we),
      .cmd       (cmd)
   );

   otc_ctrl_regs #(
      .PTR_W (PTR_W),
      .CNT_W (CNT_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_we   (base_we),
      .count_we  (count_we),
      .cmd       (cmd),
      .wdata     (cfg_wdata),
      .walk_done (walk_done),
      .base_q    (base_q),
      .count_q   (count_q),
      .ctrl_q    (ctrl_out),
      .busy      (busy),
      .irq       (irq)
   );

   otc_walker #(
      .PTR_W     (PTR_W),
      .CNT_W     (CNT_W),
      .MEM_FLOOR (MEM_FLOOR)
   ) i_walker (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (cmd == OTC_CMD_RUN),
      .base         (base_q),
      .count        (count_q),
      .mem_wr_valid (mem_wr_valid),
      .mem_wr_ready (mem_wr_ready),
      .mem_wr_addr  (mem_wr_addr),
      .mem_wr_data  (mem_wr_data),
      .done         (walk_done)
   );

   assert_write_only_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> ctrl_out[OTC_BUSY_BIT]);

endmodule

// File: tb/test_otc_clear_dma.sv
`timescale 1ns/1ps
module test_otc_clear_dma;

   localparam int PTR_W = 24;
   localparam int FLOOR = 0;
   localparam logic [31:0] RUN  = 32'h1100_0002;
   localparam logic [31:0] TERM = 32'h00FF_FFFF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = 2'd0;
   logic [31:0]       cfg_wdata = '0;
   logic [31:0]       ctrl_out;
   logic              irq;
   logic              mem_wr_valid;
   logic              mem_wr_ready = 1'b1;
   logic [PTR_W-1:0]  mem_wr_addr;
   logic [31:0]       mem_wr_data;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int ready_mode = 0;
   int irq_seen = 0;
   int stall_err = 0;
   int log_n = 0;
   logic [31:0] log_addr [64];
   logic [31:0] log_data [64];
   logic        prev_stall = 1'b0;
   logic [31:0] prev_addr = '0;
   logic [31:0] prev_data = '0;

   always #10 clk = ~clk;

   otc_clear_dma #(.PTR_W(PTR_W), .CNT_W(24), .MEM_FLOOR(FLOOR)) i_otc_clear_dma (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_sel      (cfg_sel),
      .cfg_wdata    (cfg_wdata),
      .ctrl_out     (ctrl_out),
      .irq          (irq),
      .mem_wr_valid (mem_wr_valid),
      .mem_wr_ready (mem_wr_ready),
      .mem_wr_addr  (mem_wr_addr),
      .mem_wr_data  (mem_wr_data)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (ready_mode == 0)      mem_wr_ready = 1'b1;
      else if (ready_mode == 1) mem_wr_ready = (cyc % 3) != 0;
      else                      mem_wr_ready = 1'b0;
   end

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (prev_stall && !(mem_wr_valid && 32'(mem_wr_addr) == prev_addr && mem_wr_data == prev_data))
            stall_err = stall_err + 1;
         prev_stall = mem_wr_valid && !mem_wr_ready;
         prev_addr  = 32'(mem_wr_addr);
         prev_data  = mem_wr_data;
         if (mem_wr_valid && mem_wr_ready) begin
            if (log_n < 64) begin
               log_addr[log_n] = 32'(mem_wr_addr);
               log_data[log_n] = mem_wr_data;
            end
            log_n = log_n + 1;
         end
         if (irq) irq_seen = irq_seen + 1;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp = n_cmp + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_log();
      log_n = 0;
      irq_seen = 0;
      stall_err = 0;
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_irq(input string tag);
      for (int i = 0; i < 5000 && irq_seen == 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(irq_seen == 1, tag, 32'(irq_seen), 32'd1);
   endtask

   task automatic check_log(input string tag, input logic [31:0] base, input int count);
      logic [31:0] abase;
      int room, k;
      abase = base & ~32'd3;
      room  = int'((abase - FLOOR) / 4) + 1;
      k     = (count == 0) ? 1 : ((count < room) ? count : room);
      chk(log_n == k, {tag, " entry count"}, 32'(log_n), 32'(k));
      for (int i = 0; i < k && i < log_n && i < 64; i++) begin
         logic [31:0] ea, ed;
         ea = abase - 32'(4 * i);
         ed = (i == k - 1) ? TERM : ((ea - 32'd4) & 32'h00FF_FFFF);
         chk(log_addr[i] == ea, {tag, " addr"}, log_addr[i], ea);
         chk(log_data[i] == ed, {tag, " data"}, log_data[i], ed);
      end
      chk(ctrl_out == 32'h0000_0002, {tag, " R8 ctrl after done"}, ctrl_out, 32'h2);
      chk(stall_err == 0, {tag, " R10 stall hold"}, 32'(stall_err), 32'd0);
   endtask

   task automatic do_walk(input string tag, input logic [31:0] base, input int count, input int mode);
      ready_mode = mode;
      clear_log();
      wr_reg(2'd0, base);
      wr_reg(2'd1, 32'(count));
      wr_reg(2'd2, RUN);
      wait_irq({tag, " R8 irq pulse"});
      check_log(tag, base, count);
   endtask

   task automatic t_reset();
      chk(ctrl_out == 32'h0, "R1 ctrl reset", ctrl_out, 32'h0);
      chk(irq == 1'b0, "R1 irq reset", 32'(irq), 32'h0);
      chk(mem_wr_valid == 1'b0, "R1 valid reset", 32'(mem_wr_valid), 32'h0);
   endtask

   task automatic t_stall_and_ignore();
      ready_mode = 2;
      clear_log();
      wr_reg(2'd0, 32'h500);
      wr_reg(2'd1, 32'd2);
      wr_reg(2'd2, RUN);
      repeat (4) @(negedge clk);
      #2;
      chk(ctrl_out == RUN, "R2 busy during walk", ctrl_out, RUN);
      chk(mem_wr_valid && 32'(mem_wr_addr) == 32'h500, "R2 first entry presented", 32'(mem_wr_addr), 32'h500);
      wr_reg(2'd0, 32'h900);
      wr_reg(2'd1, 32'd7);
      wr_reg(2'd2, 32'h0000_0055);
      chk(ctrl_out == RUN, "R11 ctrl write ignored while busy", ctrl_out, RUN);
      ready_mode = 0;
      wait_irq("R8 irq after stall");
      check_log("R10 stalled walk", 32'h500, 2);
      clear_log();
      wr_reg(2'd2, RUN);
      wait_irq("R11 rerun irq");
      check_log("R11 base and count kept", 32'h500, 2);
   endtask

   task automatic t_collide();
      ready_mode = 0;
      clear_log();
      wr_reg(2'd0, 32'h100);
      wr_reg(2'd1, 32'd4);
      wr_reg(2'd2, RUN);
      repeat (3) @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = RUN;
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (6) @(negedge clk);
      #2;
      chk(irq_seen == 1, "R11 collision irq", 32'(irq_seen), 32'd1);
      chk(mem_wr_valid == 1'b0, "R11 no restart at completion", 32'(mem_wr_valid), 32'd0);
      check_log("R11 collision walk", 32'h100, 4);
   endtask

   task automatic t_reject();
      ready_mode = 0;
      clear_log();
      wr_reg(2'd2, 32'h0100_0201);
      repeat (4) @(negedge clk);
      chk(ctrl_out == 32'h0000_0201, "R9 rejected ctrl value", ctrl_out, 32'h201);
      chk(irq_seen == 1, "R9 rejected irq", 32'(irq_seen), 32'd1);
      chk(log_n == 0, "R9 no memory writes", 32'(log_n), 32'd0);
   endtask

   task automatic t_store();
      ready_mode = 0;
      clear_log();
      wr_reg(2'd2, 32'h0000_0002);
      repeat (10) @(negedge clk);
      chk(ctrl_out == 32'h0000_0002, "R12 stored ctrl", ctrl_out, 32'h2);
      chk(irq_seen == 0, "R12 no irq", 32'(irq_seen), 32'd0);
      chk(log_n == 0, "R12 no memory writes", 32'(log_n), 32'd0);
   endtask

   initial begin
      #(20 * 150000);
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      t_reset();
      do_walk("R4 R5 basic", 32'h1000, 5, 0);
      do_walk("R3 aligned start", 32'h2007, 3, 1);
      do_walk("R6 zero count", 32'h300, 0, 0);
      do_walk("R7 floor stop", 32'h8, 10, 0);
      do_walk("R5 single entry", 32'h40, 1, 1);
      t_stall_and_ignore();
      t_collide();
      t_reject();
      t_store();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule